// File: doc/BRIEF.md
# DTMF Tone Pair Period Classifier

This block recognises a dual-tone keypad signal after the analog front end has already split it into two bands and squared each band into a one-bit logic waveform. It measures the time between rising edges of each waveform in system-clock cycles. It then matches each measured period against four acceptance windows per band: 697, 770, 852 and 941 Hz for the row band, and 1209, 1336, 1477 and 1633 Hz for the column band. A band is declared valid only after several consecutive periods fall into the same window. When both bands are valid together, the block raises a tone-present flag and drives the 4-bit key code.

Each window is centred on the nominal period and reaches a configurable number of per-mille to either side. The default of 25 per-mille lies between the 1.5 % deviation that must pass and the 3.5 % deviation that must fail. A band loses its valid status when a period lands outside every window, when a period lands in a different window, or when no rising edge arrives for twice the slowest accepted period. An inhibit input suppresses every key in the 1633 Hz column. The last reported code is held after the tone goes away, so a reader can fetch it after the present flag drops.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: A row-band square wave whose frequency is within 1.5 % of 697, 770, 852 or 941 Hz is classified as that row.
- R2: A column-band square wave whose frequency is within 1.5 % of 1209, 1336, 1477 or 1633 Hz is classified as that column.
- R3: A square wave in either band that is off by 3.5 % or more from every nominal frequency of its band never makes that band valid. The tone-present flag then stays low and the held code is unchanged.
- R4: The key code for row r (0..3, from lowest frequency) and column c (0..3, from lowest frequency) is 3r+c+1 when r<3 and c<3. Row 3 gives 1011 for column 0, 1010 for column 1 and 1100 for column 2. Column 3 gives 1101, 1110 and 1111 for rows 0 to 2, and 0000 for row 3.
- R5: While the inhibit input is high, no pair that uses the 1633 Hz column raises the tone-present flag.
- R6: The inhibit input has no effect on pairs in columns 0 to 2. With inhibit low, column-3 pairs are reported normally.
- R7: A band becomes valid only after CONFIRM_PERIODS consecutive periods (default 4) fall into the same window. A burst with fewer periods is not reported.
- R8: If a band sees no rising edge for twice the slowest accepted row period, that band is cleared, the tone-present flag falls, and the key code holds its last reported value.
- R9: The tone-present flag is high only when both bands are valid at the same time. A tone in a single band is never reported.
- R10: After reset the tone-present flag is low and the key code is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Synchronous active-low reset |
| row_sq | input | 1 | Squared row-band signal (asynchronous) |
| col_sq | input | 1 | Squared column-band signal (asynchronous) |
| inhibit | input | 1 | High suppresses the 1633 Hz column |
| tone_present | output | 1 | A confirmed, permitted pair is present |
| tone_digit | output | 4 | Key code of the last reported pair |

## Verification
The bench builds the block with CLK_HZ set to 200000 and the defaults for tolerance and confirmation count. At that clock the nominal periods run from about 122 to 287 cycles, so a tone, its confirmation and its timeout together take only a few thousand cycles. This makes it possible to sweep all sixteen keys, every frequency at plus and minus 1.5 % and 3.5 %, and every column-3 key under inhibit. At this clock the 1.5 % and 3.5 % deviations still differ by several cycles per period, so the window edges are exercised on integer periods, not lost in rounding.

// File: rtl/dtmf_cls_pkg.sv
// Package: shared types and constant functions for the tone pair classifier.
// Assumes frequencies in Hz and tolerances in per-mille of the nominal period.
package dtmf_cls_pkg;

    localparam int unsigned NUM_TONES = 4;

    typedef logic [1:0] tone_idx_t;
    typedef logic [3:0] key_code_t;

    // Nominal frequency of tone k in the row (high_band=0) or column band.
    function automatic int unsigned tone_hz(bit high_band, int unsigned k);
        int unsigned f;
        if (high_band) begin
            case (k)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end else begin
            case (k)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end
        return f;
    endfunction

    // Shortest accepted period in clocks: ceiling of clk*(1-tol)/f.
    function automatic int unsigned win_min(int unsigned clk_hz, int unsigned f,
                                            int unsigned tol_pm);
        longint unsigned num;
        longint unsigned den;
        num = longint'(clk_hz) * longint'(1000 - tol_pm);
        den = longint'(f) * 64'd1000;
        return int'((num + den - 64'd1) / den);
    endfunction

    // Longest accepted period in clocks: floor of clk*(1+tol)/f.
    function automatic int unsigned win_max(int unsigned clk_hz, int unsigned f,
                                            int unsigned tol_pm);
        longint unsigned num;
        longint unsigned den;
        num = longint'(clk_hz) * longint'(1000 + tol_pm);
        den = longint'(f) * 64'd1000;
        return int'(num / den);
    endfunction

    // Key code of a row/column pair.
    function automatic key_code_t pair_code(tone_idx_t row, tone_idx_t col);
        key_code_t c;
        if (col == 2'd3) begin
            c = (row == 2'd3) ? 4'd0 : (4'd13 + {2'b00, row});
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end else begin
            c = 4'd1 + {2'b00, col} + ({2'b00, row} << 1) + {2'b00, row};
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_edge_det.sv
// Module: brings an asynchronous squared tone into the clock domain and
// flags each rising edge with a one-cycle pulse.
// Assumes the input toggles far slower than the clock.
module dtmf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_in,
    output logic rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sq_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Pulse when the synchronised level goes from low to high.
    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/dtmf_group_meter.sv
// Module: measures the period between rising edges of one band, matches it
// against the four acceptance windows of that band, and raises grp_valid
// once CONFIRM periods in a row hit the same window. An edge gap reaching
// TIMEOUT clears the band and forgets the reference edge.
// Assumes the windows of one band do not overlap (true for tolerances of a
// few percent) and that TIMEOUT exceeds every window's upper bound.
module dtmf_group_meter
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 3579545,
    parameter int unsigned TOL_PERMILLE = 25,
    parameter bit          HIGH_BAND    = 1'b0,
    parameter int unsigned CONFIRM      = 4,
    parameter int unsigned TIMEOUT      = 10530,
    localparam int unsigned CW          = $clog2(TIMEOUT + 2),
    localparam int unsigned SW          = $clog2(CONFIRM + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise,
    output logic      grp_valid,
    output tone_idx_t grp_idx
);

    logic [CW-1:0]        cnt_q;
    logic [CW-1:0]        period;
    logic                 have_ref_q;
    logic [SW-1:0]        streak_q;
    tone_idx_t            idx_q;
    logic                 valid_q;
    logic [NUM_TONES-1:0] hit;
    logic                 any_hit;
    tone_idx_t            hit_idx;

    // Period just completed by this edge, in clock cycles.
    assign period = cnt_q + CW'(1);

    // One comparator pair per window, bounds derived from the clock rate.
    for (genvar k = 0; k < NUM_TONES; k++) begin : g_win
        localparam int unsigned F  = tone_hz(HIGH_BAND, k);
        localparam int unsigned LO = win_min(CLK_HZ, F, TOL_PERMILLE);
        localparam int unsigned HI = win_max(CLK_HZ, F, TOL_PERMILLE);
        assign hit[k] = (period >= CW'(LO)) && (period <= CW'(HI));
    end

    // Encode which window (if any) the period landed in.
    always_comb begin
        any_hit = |hit;
        hit_idx = '0;
        for (int k = 0; k < NUM_TONES; k++) begin
            if (hit[k]) hit_idx = tone_idx_t'(k);
        end
    end

    // Edge-gap counter, agreement streak and band-valid state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            have_ref_q <= 1'b0;
            streak_q   <= '0;
            idx_q      <= '0;
            valid_q    <= 1'b0;
        end else if (rise) begin
            cnt_q      <= '0;
            have_ref_q <= 1'b1;
            if (have_ref_q) begin
                if (any_hit && (streak_q != '0) && (hit_idx == idx_q)) begin
                    if (streak_q < SW'(CONFIRM)) streak_q <= streak_q + SW'(1);
                    if (streak_q >= SW'(CONFIRM - 1)) valid_q <= 1'b1;
                end else if (any_hit) begin
                    idx_q    <= hit_idx;
                    streak_q <= SW'(1);
                    valid_q  <= (CONFIRM <= 1);
                end else begin
                    streak_q <= '0;
                    valid_q  <= 1'b0;
                end
            end
        end else if (cnt_q == CW'(TIMEOUT)) begin
            have_ref_q <= 1'b0;
            streak_q   <= '0;
            valid_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign grp_valid = valid_q;
    assign grp_idx   = idx_q;

endmodule

// File: rtl/dtmf_code_map.sv
// Module: combines the two band results into a permitted/not-permitted flag
// and the key code of the pair. Purely combinational.
// Assumes column index 3 is the 1633 Hz column.
module dtmf_code_map
    import dtmf_cls_pkg::*;
(
    input  logic      row_valid,
    input  tone_idx_t row_idx,
    input  logic      col_valid,
    input  tone_idx_t col_idx,
    input  logic      inhibit,
    output logic      pair_ok,
    output key_code_t code
);

    logic blocked;

    // Inhibit removes the whole fourth column from consideration.
    assign blocked = inhibit && (col_idx == 2'd3);

    // A pair counts only with both bands valid and the column permitted.
    assign pair_ok = row_valid && col_valid && !blocked;

    // Key code of the current pair.
    assign code = pair_code(row_idx, col_idx);

endmodule

// File: rtl/dtmf_pair_classifier.sv
// Module: top of the tone pair classifier. Two edge detectors, two band
// meters and a code map; the result is registered and the code is held
// while no pair is present.
// Assumes row_sq/col_sq are squared band signals, asynchronous to clk.
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 3579545,
    parameter int unsigned TOL_PERMILLE    = 25,
    parameter int unsigned CONFIRM_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_sq,
    input  logic       col_sq,
    input  logic       inhibit,
    output logic       tone_present,
    output logic [3:0] tone_digit
);

    localparam int unsigned SLOWEST = win_max(CLK_HZ, tone_hz(1'b0, 0), TOL_PERMILLE);
    localparam int unsigned TIMEOUT = 2 * SLOWEST;

    logic      row_rise;
    logic      col_rise;
    logic      row_valid;
    logic      col_valid;
    tone_idx_t row_idx;
    tone_idx_t col_idx;
    logic      pair_ok;
    key_code_t code;

    dtmf_edge_det u_row_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sq_in (row_sq),
        .rise  (row_rise)
    );

    dtmf_edge_det u_col_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sq_in (col_sq),
        .rise  (col_rise)
    );

    dtmf_group_meter #(
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL_PERMILLE),
        .HIGH_BAND    (1'b0),
        .CONFIRM      (CONFIRM_PERIODS),
        .TIMEOUT      (TIMEOUT)
    ) u_row_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (row_rise),
        .grp_valid (row_valid),
        .grp_idx   (row_idx)
    );

    dtmf_group_meter #(
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL_PERMILLE),
        .HIGH_BAND    (1'b1),
        .CONFIRM      (CONFIRM_PERIODS),
        .TIMEOUT      (TIMEOUT)
    ) u_col_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (col_rise),
        .grp_valid (col_valid),
        .grp_idx   (col_idx)
    );

    dtmf_code_map u_map (
        .row_valid (row_valid),
        .row_idx   (row_idx),
        .col_valid (col_valid),
        .col_idx   (col_idx),
        .inhibit   (inhibit),
        .pair_ok   (pair_ok),
        .code      (code)
    );

    // Output register: flag follows the pair, code updates only when present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_present <= 1'b0;
            tone_digit   <= 4'd0;
        end else begin
            tone_present <= pair_ok;
            if (pair_ok) tone_digit <= code;
        end
    end

endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
// Module: temporal checks on the tone pair classifier, bound to its top.
// Assumes TIMEOUT matches the top's edge-gap limit.
module dtmf_pair_classifier_chk #(
    parameter int unsigned TIMEOUT = 10530
) (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit,
    input logic       row_rise,
    input logic       row_valid,
    input logic       col_valid,
    input logic [1:0] col_idx,
    input logic       tone_present,
    input logic [3:0] tone_digit
);

    int unsigned gap_q;

    // Cycles since the last row edge, saturating just past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gap_q <= 0;
        else if (row_rise)           gap_q <= 0;
        else if (gap_q < TIMEOUT + 2) gap_q <= gap_q + 1;
    end

    p_both_bands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tone_present |-> $past(row_valid && col_valid));

    p_inhibit_col4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tone_present |-> !($past(inhibit) && ($past(col_idx) == 2'd3)));

    p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_present |-> $stable(tone_digit));

    p_valid_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_valid) |-> $past(row_rise));

    p_gap_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q > TIMEOUT + 1) |-> !row_valid);

endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit      (inhibit),
    .row_rise     (row_rise),
    .row_valid    (row_valid),
    .col_valid    (col_valid),
    .col_idx      (col_idx),
    .tone_present (tone_present),
    .tone_digit   (tone_digit)
);

// File: tb/dtmf_pair_classifier_tb.sv
module dtmf_pair_classifier_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 200000;
    localparam int GAP_LIMIT  = 2 * 294;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_sq = 1'b0;
    logic       col_sq = 1'b0;
    logic       inhibit = 1'b0;
    logic       tone_present;
    logic [3:0] tone_digit;

    int row_per = 0;
    int col_per = 0;
    int row_ph = 0;
    int col_ph = 0;
    int n_checks = 0;
    int n_fail = 0;
    int held = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dtmf_pair_classifier #(.CLK_HZ(TB_CLK_HZ)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_sq       (row_sq),
        .col_sq       (col_sq),
        .inhibit      (inhibit),
        .tone_present (tone_present),
        .tone_digit   (tone_digit)
    );

    // Square wave generators driven away from the active edge.
    always @(negedge clk) begin
        if (row_per == 0) begin row_ph <= 0; row_sq <= 1'b0; end
        else begin
            row_sq <= (row_ph < row_per / 2);
            row_ph <= (row_ph + 1 >= row_per) ? 0 : row_ph + 1;
        end
        if (col_per == 0) begin col_ph <= 0; col_sq <= 1'b0; end
        else begin
            col_sq <= (col_ph < col_per / 2);
            col_ph <= (col_ph + 1 >= col_per) ? 0 : col_ph + 1;
        end
    end

    function automatic int freq(bit high, int k);
        int lo[4] = '{697, 770, 852, 941};
        int hi[4] = '{1209, 1336, 1477, 1633};
        return high ? hi[k] : lo[k];
    endfunction

    // Period in clocks of frequency f shifted by dev per-mille (rounded).
    function automatic int per_of(int f, int dev);
        real p;
        p = real'(TB_CLK_HZ) / (real'(f) * (1.0 + real'(dev) / 1000.0));
        return $rtoi(p + 0.5);
    endfunction

    function automatic int key_of(int r, int c);
        if (c == 3) return (r == 3) ? 0 : 13 + r;
        if (r < 3) return 3 * r + c + 1;
        if (c == 0) return 11;
        if (c == 1) return 10;
        return 12;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a pair of periods (0 = silent), check the result, then go silent
    // and check the gap clears presence while the code is held.
    task automatic run_pair(string req, int rp, int cp, bit inh, bit exp_on, int exp_key);
        int mx;
        mx = (rp > cp) ? rp : cp;
        @(posedge clk);
        inhibit = inh;
        row_per = rp;
        col_per = cp;
        repeat (5 * mx + 40) @(posedge clk);
        @(negedge clk);
        if (exp_on) held = exp_key;
        check({req, " present"}, int'(tone_present), int'(exp_on));
        check({req, " code"}, int'(tone_digit), held);
        @(posedge clk);
        row_per = 0;
        col_per = 0;
        repeat (GAP_LIMIT + mx + 40) @(posedge clk);
        @(negedge clk);
        check({req, " R8 gap clears"}, int'(tone_present), 0);
        check({req, " R8 code held"}, int'(tone_digit), held);
        inhibit = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R10 reset present", int'(tone_present), 0);
        check("R10 reset code", int'(tone_digit), 0);
        rst_n = 1'b1;

        // R1 R2 R4: all sixteen keys at nominal frequency, inhibit low (R6).
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                run_pair("R4 nominal", per_of(freq(0, r), 0), per_of(freq(1, c), 0),
                         1'b0, 1'b1, key_of(r, c));

        // R5: column-3 keys suppressed under inhibit.
        for (int r = 0; r < 4; r++)
            run_pair("R5 inhibit", per_of(freq(0, r), 0), per_of(freq(1, 3), 0),
                     1'b1, 1'b0, 0);

        // R6: inhibit has no effect on other columns.
        run_pair("R6 inhibit other", per_of(freq(0, 1), 0), per_of(freq(1, 1), 0),
                 1'b1, 1'b1, key_of(1, 1));

        // R1 R2: accepted at +/-1.5 %.
        for (int k = 0; k < 4; k++) begin
            run_pair("R1 R2 plus", per_of(freq(0, k), 15), per_of(freq(1, k), 15),
                     1'b0, 1'b1, key_of(k, k));
            run_pair("R1 R2 minus", per_of(freq(0, k), -15), per_of(freq(1, k), -15),
                     1'b0, 1'b1, key_of(k, k));
        end

        // R3: rejected at +/-3.5 % in either band.
        for (int k = 0; k < 4; k++) begin
            run_pair("R3 row plus", per_of(freq(0, k), 35), per_of(freq(1, 0), 0), 1'b0, 1'b0, 0);
            run_pair("R3 row minus", per_of(freq(0, k), -35), per_of(freq(1, 0), 0), 1'b0, 1'b0, 0);
            run_pair("R3 col plus", per_of(freq(0, 0), 0), per_of(freq(1, k), 35), 1'b0, 1'b0, 0);
            run_pair("R3 col minus", per_of(freq(0, 0), 0), per_of(freq(1, k), -35), 1'b0, 1'b0, 0);
        end

        // R9: single-band tones never reported.
        run_pair("R9 row only", per_of(freq(0, 2), 0), 0, 1'b0, 1'b0, 0);
        run_pair("R9 col only", 0, per_of(freq(1, 2), 0), 1'b0, 1'b0, 0);

        // R7: a burst of two row periods is too short to confirm.
        begin
            int rp;
            rp = per_of(freq(0, 0), 0);
            @(posedge clk);
            row_per = rp;
            col_per = per_of(freq(1, 0), 0);
            repeat (2 * rp) @(posedge clk);
            row_per = 0;
            repeat (rp + 20) @(posedge clk);
            @(negedge clk);
            check("R7 short burst present", int'(tone_present), 0);
            check("R7 short burst code", int'(tone_digit), held);
            @(posedge clk);
            col_per = 0;
            repeat (GAP_LIMIT + 300) @(posedge clk);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule